// File: doc/BRIEF.md
# Safeload Transfer Controller

This block lets a host update a handful of coefficient words without the processing core ever seeing a half-updated set. The host fills a small bank of staging slots, each an address and a data word, and then sets a command bit. Nothing moves at once. The copy waits for the next frame-boundary strobe and then runs at that safe point. It copies the staged words into one of two memories: the parameter RAM or the target/slew RAM.

Only slots that received a data write since their last copy are written out. Slots that were not refreshed are skipped, so a stale word never overwrites a newer value in memory. The command bits double as status. Each one reads back as 1 while its copy is pending or running, and it drops to 0 on its own when the copy ends. The two memories appear only as one shared write port with a select line.

Top module: `safeload_ctrl`

## Requirements
- R1: After reset both command bits read 0, the RAM write enable is 0 and no slot is marked fresh.
- R2: A host write of kind 1 (data) to slot s stores the word and marks slot s fresh. A write of kind 0 (address) stores the low ADDR_W bits as the slot's address and does not mark the slot fresh.
- R3: A copy starts only on a frame strobe sampled in a cycle after the one in which its command bit was written. A strobe in the same cycle as the command write does not start it. No RAM write occurs outside a copy.
- R4: A copy scans the slots in ascending order, one slot per clock, and lasts exactly NUM_SLOTS cycles (5 by default). Slot k appears on the RAM port k+1 cycles after the starting strobe edge.
- R5: During the scan a fresh slot produces exactly one RAM write, and a slot that is not fresh produces none.
- R6: A slot's fresh mark clears when that slot is copied. A second copy with no new data writes performs no RAM writes.
- R7: The RAM address equals the slot's stored address unchanged, so address 0 selects the first location of the chosen memory. The RAM data equals the slot's stored data word.
- R8: The RAM select reads 0 for the parameter RAM and 1 for the target/slew RAM.
- R9: A command bit reads 1 from the write that sets it until the last scan cycle of its copy, and then reads 0.
- R10: If both command bits are pending at a strobe, the parameter RAM copy runs first. The target copy waits for a later strobe and sees only the slots refreshed in between.
- R11: While a copy runs, every host write (slot address, slot data and command) is ignored.
- R12: A command write (kind 2) sets the parameter bit from value bit 0 and the target bit from value bit 1. Writing 0 to a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en_i | input | 1 | Host write strobe |
| host_wr_kind_i | input | 2 | 0 slot address, 1 slot data, 2 command, 3 unused |
| host_wr_slot_i | input | SLOT_W | Staging slot index |
| host_wr_val_i | input | DATA_W | Write value |
| frame_strobe_i | input | 1 | One-cycle frame-boundary pulse |
| cmd_param_o | output | 1 | Parameter RAM copy pending or running |
| cmd_target_o | output | 1 | Target/slew RAM copy pending or running |
| ram_we_o | output | 1 | RAM write enable |
| ram_sel_o | output | 1 | 0 parameter RAM, 1 target/slew RAM |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_data_o | output | DATA_W | RAM write data |

## Verification
The assertions take two things for granted. Slot indexes beyond the last slot never reach the staging bank, and host writes during a copy are blocked by the host gate before they reach either store. The frame strobe itself is allowed in any cycle. The stimulus changes every input on the falling clock edge and holds it for one cycle. Some strobes are placed deliberately in the same cycle as a command write, and some host writes land in the middle of a scan, so those paths are exercised within the same input rules.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [1:0] {
        HK_ADDR = 2'd0,
        HK_DATA = 2'd1,
        HK_CMD  = 2'd2,
        HK_RSVD = 2'd3
    } host_kind_e;

    typedef enum logic {
        RS_PARAM  = 1'b0,
        RS_TARGET = 1'b1
    } ram_sel_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_XFER = 1'b1
    } seq_state_e;

    localparam int CMD_PARAM_BIT  = 0;
    localparam int CMD_TARGET_BIT = 1;
    localparam int CMD_W          = 2;

endpackage

// File: rtl/sl_host_decode.sv
module sl_host_decode
    import sl_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 3
) (
    input  logic              wr_en_i,
    input  logic [1:0]        wr_kind_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [CMD_W-1:0]  wr_cmd_bits_i,
    input  logic              busy_i,
    output logic              addr_we_o,
    output logic              data_we_o,
    output logic [CMD_W-1:0]  cmd_set_o
);

    localparam logic [SLOT_W:0] SLOT_LIMIT = (SLOT_W+1)'(NUM_SLOTS);

    logic accept;
    logic slot_ok;
    host_kind_e kind;

    always_comb begin
        kind      = host_kind_e'(wr_kind_i);
        accept    = wr_en_i && !busy_i;
        slot_ok   = ({1'b0, wr_slot_i} < SLOT_LIMIT);
        addr_we_o = accept && slot_ok && (kind == HK_ADDR);
        data_we_o = accept && slot_ok && (kind == HK_DATA);
        cmd_set_o = (accept && (kind == HK_CMD)) ? wr_cmd_bits_i : '0;
    end

endmodule

// File: rtl/sl_slot_bank.sv
module sl_slot_bank #(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 3,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             addr_we_i,
    input  logic                             data_we_i,
    input  logic [SLOT_W-1:0]                slot_i,
    input  logic [DATA_W-1:0]                val_i,
    input  logic                             clr_en_i,
    input  logic [SLOT_W-1:0]                clr_slot_i,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr_o,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data_o,
    output logic [NUM_SLOTS-1:0]             slot_fresh_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] data;
        logic [NUM_SLOTS-1:0]             fresh;
    } bank_t;

    bank_t bank_d, bank_q;

    logic [NUM_SLOTS-1:0] hit_addr;
    logic [NUM_SLOTS-1:0] hit_data;
    logic [NUM_SLOTS-1:0] hit_clr;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot_match
        assign hit_addr[g] = addr_we_i && (slot_i == SLOT_W'(g));
        assign hit_data[g] = data_we_i && (slot_i == SLOT_W'(g));
        assign hit_clr[g]  = clr_en_i  && (clr_slot_i == SLOT_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit_addr[i]) begin
                bank_d.addr[i] = val_i[ADDR_W-1:0];
            end
            if (hit_data[i]) begin
                bank_d.data[i]  = val_i;
                bank_d.fresh[i] = 1'b1;
            end
            if (hit_clr[i]) begin
                bank_d.fresh[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign slot_addr_o  = bank_q.addr;
    assign slot_data_o  = bank_q.data;
    assign slot_fresh_o = bank_q.fresh;

    // R2: a data write leaves its slot marked fresh
    assert_fresh_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        data_we_i |=> slot_fresh_o[$past(slot_i)]);

    // R6: only a fresh slot is cleared, and it is clear afterwards
    assert_clear_only_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |-> slot_fresh_o[clr_slot_i]);

    assert_cleared_after_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> !slot_fresh_o[$past(clr_slot_i)]);

endmodule

// File: rtl/sl_sequencer.sv
module sl_sequencer
    import sl_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int SLOT_W    = 3,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 24
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frame_strobe_i,
    input  logic [CMD_W-1:0]                 cmd_set_i,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr_i,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data_i,
    input  logic [NUM_SLOTS-1:0]             slot_fresh_i,
    output logic                             clr_en_o,
    output logic [SLOT_W-1:0]                clr_slot_o,
    output logic                             busy_o,
    output logic [CMD_W-1:0]                 cmd_o,
    output logic                             ram_we_o,
    output logic                             ram_sel_o,
    output logic [ADDR_W-1:0]                ram_addr_o,
    output logic [DATA_W-1:0]                ram_data_o
);

    localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        seq_state_e         st;
        ram_sel_e           sel;
        logic [SLOT_W-1:0]  idx;
        logic [CMD_W-1:0]   cmd;
        logic               we;
        ram_sel_e           rsel;
        logic [ADDR_W-1:0]  raddr;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              pick_fresh;
    logic [ADDR_W-1:0] pick_addr;
    logic [DATA_W-1:0] pick_data;

    // slot multiplexer for the current scan position
    always_comb begin
        pick_fresh = 1'b0;
        pick_addr  = '0;
        pick_data  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (seq_q.idx == SLOT_W'(i)) begin
                pick_fresh = slot_fresh_i[i];
                pick_addr  = slot_addr_i[i];
                pick_data  = slot_data_i[i];
            end
        end
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.we   = 1'b0;
        seq_d.cmd  = seq_q.cmd | cmd_set_i;
        clr_en_o   = 1'b0;
        clr_slot_o = seq_q.idx;

        unique case (seq_q.st)
            SQ_IDLE: begin
                if (frame_strobe_i && (|seq_q.cmd)) begin
                    seq_d.st  = SQ_XFER;
                    seq_d.idx = '0;
                    seq_d.sel = seq_q.cmd[CMD_PARAM_BIT] ? RS_PARAM : RS_TARGET;
                end
            end
            SQ_XFER: begin
                seq_d.we = pick_fresh;
                clr_en_o = pick_fresh;
                if (pick_fresh) begin
                    seq_d.rsel  = seq_q.sel;
                    seq_d.raddr = pick_addr;
                    seq_d.rdata = pick_data;
                end
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.st = SQ_IDLE;
                    if (seq_q.sel == RS_PARAM) begin
                        seq_d.cmd[CMD_PARAM_BIT] = 1'b0;
                    end else begin
                        seq_d.cmd[CMD_TARGET_BIT] = 1'b0;
                    end
                end else begin
                    seq_d.idx = seq_q.idx + SLOT_W'(1);
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, sel: RS_PARAM, idx: '0, cmd: '0, we: 1'b0,
                       rsel: RS_PARAM, raddr: '0, rdata: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o     = (seq_q.st == SQ_XFER);
    assign cmd_o      = seq_q.cmd;
    assign ram_we_o   = seq_q.we;
    assign ram_sel_o  = seq_q.rsel;
    assign ram_addr_o = seq_q.raddr;
    assign ram_data_o = seq_q.rdata;

    // R3: a RAM write only follows a scan cycle
    assert_write_in_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.we |-> $past(seq_q.st == SQ_XFER));

    // R4: scan position advances by one each clock
    assert_ascending_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_XFER && seq_q.idx != '0)
            |-> ($past(seq_q.st == SQ_XFER) && seq_q.idx == $past(seq_q.idx) + SLOT_W'(1)));

    // R9: a command bit only falls at the end of its own copy
    assert_param_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.cmd[CMD_PARAM_BIT])
            |-> $past(seq_q.st == SQ_XFER && seq_q.sel == RS_PARAM && seq_q.idx == LAST_IDX));

    assert_target_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.cmd[CMD_TARGET_BIT])
            |-> $past(seq_q.st == SQ_XFER && seq_q.sel == RS_TARGET && seq_q.idx == LAST_IDX));

    // R10: a pending parameter copy always wins the start
    assert_param_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && $past(seq_q.cmd[CMD_PARAM_BIT])) |-> (seq_q.sel == RS_PARAM));

endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
    import sl_pkg::*;
#(
    parameter int NUM_SLOTS = 5,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 24,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en_i,
    input  logic [1:0]        host_wr_kind_i,
    input  logic [SLOT_W-1:0] host_wr_slot_i,
    input  logic [DATA_W-1:0] host_wr_val_i,
    input  logic              frame_strobe_i,
    output logic              cmd_param_o,
    output logic              cmd_target_o,
    output logic              ram_we_o,
    output logic              ram_sel_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_data_o
);

    logic                             busy;
    logic                             addr_we;
    logic                             data_we;
    logic [CMD_W-1:0]                 cmd_set;
    logic [CMD_W-1:0]                 cmd_q;
    logic                             clr_en;
    logic [SLOT_W-1:0]                clr_slot;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
    logic [NUM_SLOTS-1:0]             slot_fresh;

    sl_host_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .wr_en_i       (host_wr_en_i),
        .wr_kind_i     (host_wr_kind_i),
        .wr_slot_i     (host_wr_slot_i),
        .wr_cmd_bits_i (host_wr_val_i[CMD_W-1:0]),
        .busy_i        (busy),
        .addr_we_o     (addr_we),
        .data_we_o     (data_we),
        .cmd_set_o     (cmd_set)
    );

    sl_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_we_i    (addr_we),
        .data_we_i    (data_we),
        .slot_i       (host_wr_slot_i),
        .val_i        (host_wr_val_i),
        .clr_en_i     (clr_en),
        .clr_slot_i   (clr_slot),
        .slot_addr_o  (slot_addr),
        .slot_data_o  (slot_data),
        .slot_fresh_o (slot_fresh)
    );

    sl_sequencer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_strobe_i (frame_strobe_i),
        .cmd_set_i      (cmd_set),
        .slot_addr_i    (slot_addr),
        .slot_data_i    (slot_data),
        .slot_fresh_i   (slot_fresh),
        .clr_en_o       (clr_en),
        .clr_slot_o     (clr_slot),
        .busy_o         (busy),
        .cmd_o          (cmd_q),
        .ram_we_o       (ram_we_o),
        .ram_sel_o      (ram_sel_o),
        .ram_addr_o     (ram_addr_o),
        .ram_data_o     (ram_data_o)
    );

    assign cmd_param_o  = cmd_q[CMD_PARAM_BIT];
    assign cmd_target_o = cmd_q[CMD_TARGET_BIT];

    // R11: staged words do not move while a copy is running
    assert_hold_slots_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_wr_en_i) |=> ($stable(slot_data) && $stable(slot_addr)));

    // R1: nothing is pending right after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ram_we_o && cmd_q == '0 && slot_fresh == '0));

endmodule

// File: tb/test_safeload_ctrl.sv
module test_safeload_ctrl;

    localparam int NS = 5;
    localparam int AW = 12;
    localparam int DW = 24;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [1:0]    host_wr_kind = 2'd0;
    logic [SW-1:0] host_wr_slot = '0;
    logic [DW-1:0] host_wr_val = '0;
    logic          frame_strobe = 1'b0;
    logic          cmd_param, cmd_target, ram_we, ram_sel;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_addr  [NS];
    logic [DW-1:0] m_data  [NS];
    bit            m_fresh [NS];

    // vector: slot mask[13:9], target select[8], seed[7:0]
    localparam logic [13:0] VECS [6] = '{
        {5'b11111, 1'b0, 8'd0},
        {5'b00101, 1'b1, 8'd3},
        {5'b10010, 1'b0, 8'd9},
        {5'b01000, 1'b1, 8'd20},
        {5'b10001, 1'b1, 8'd41},
        {5'b01110, 1'b0, 8'd77}
    };

    safeload_ctrl #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW)) i_safeload_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_wr_en_i   (host_wr_en),
        .host_wr_kind_i (host_wr_kind),
        .host_wr_slot_i (host_wr_slot),
        .host_wr_val_i  (host_wr_val),
        .frame_strobe_i (frame_strobe),
        .cmd_param_o    (cmd_param),
        .cmd_target_o   (cmd_target),
        .ram_we_o       (ram_we),
        .ram_sel_o      (ram_sel),
        .ram_addr_o     (ram_addr),
        .ram_data_o     (ram_data)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] k, input int s, input logic [DW-1:0] v);
        host_wr_en   = 1'b1;
        host_wr_kind = k;
        host_wr_slot = SW'(s);
        host_wr_val  = v;
        @(negedge clk);
        host_wr_en   = 1'b0;
    endtask

    task automatic write_addr(input int s, input logic [AW-1:0] a);
        host_write(2'd0, s, DW'(a));
        m_addr[s] = a;
    endtask

    task automatic write_data(input int s, input logic [DW-1:0] d);
        host_write(2'd1, s, d);
        m_data[s]  = d;
        m_fresh[s] = 1'b1;
    endtask

    task automatic command(input logic [1:0] bits);
        host_write(2'd2, 0, DW'(bits));
    endtask

    task automatic strobe();
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    // call right after strobe(); slot k is visible at the (k+1)th following falling edge
    task automatic check_xfer(input bit sel, input bit inject);
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            chk(ram_we == m_fresh[k], "R5 slot write enable", 32'(ram_we), 32'(m_fresh[k]));
            if (m_fresh[k]) begin
                chk(ram_sel == sel, "R8 ram select", 32'(ram_sel), 32'(sel));
                chk(ram_addr == m_addr[k], "R7 ram address", 32'(ram_addr), 32'(m_addr[k]));
                chk(ram_data == m_data[k], "R7 ram data", 32'(ram_data), 32'(m_data[k]));
                m_fresh[k] = 1'b0;
            end
            if (k == NS - 1) begin
                chk((sel ? cmd_target : cmd_param) == 1'b0, "R9 command cleared at end",
                    32'(sel ? cmd_target : cmd_param), 32'd0);
            end else begin
                chk((sel ? cmd_target : cmd_param) == 1'b1, "R9 command held while running",
                    32'(sel ? cmd_target : cmd_param), 32'd1);
            end
            if (inject && k == 1) begin
                host_wr_en = 1'b1; host_wr_kind = 2'd1; host_wr_slot = 3'd4; host_wr_val = 24'hBAD0BA;
            end
            if (inject && k == 2) begin
                host_wr_en = 1'b1; host_wr_kind = 2'd2; host_wr_slot = 3'd0; host_wr_val = 24'd2;
            end
            if (inject && k == 3) host_wr_en = 1'b0;
        end
        @(negedge clk);
        chk(ram_we == 1'b0, "R4 copy lasts exactly NUM_SLOTS cycles", 32'(ram_we), 32'd0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_addr[i] = '0; m_data[i] = '0; m_fresh[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cmd_param == 1'b0, "R1 param command after reset", 32'(cmd_param), 32'd0);
        chk(cmd_target == 1'b0, "R1 target command after reset", 32'(cmd_target), 32'd0);
        chk(ram_we == 1'b0, "R1 write enable after reset", 32'(ram_we), 32'd0);
        command(2'b01);
        strobe();
        check_xfer(1'b0, 1'b0);  // R1: no slot fresh, so no writes

        // vector table
        for (int v = 0; v < 6; v++) begin
            logic [4:0] mask;
            logic       sel;
            logic [7:0] seed;
            {mask, sel, seed} = VECS[v];
            for (int i = 0; i < NS; i++) begin
                if (mask[i]) begin
                    write_addr(i, AW'(int'(seed) * 7 + i));
                    write_data(i, DW'(int'(seed) * 65536 + i * 257 + 1));
                end
            end
            command(sel ? 2'b10 : 2'b01);
            @(negedge clk);
            chk(ram_we == 1'b0, "R3 no write before strobe", 32'(ram_we), 32'd0);
            chk((sel ? cmd_target : cmd_param) == 1'b1, "R12 command bit set",
                32'(sel ? cmd_target : cmd_param), 32'd1);
            strobe();
            check_xfer(sel, 1'b0);
        end

        // R6: nothing fresh, second copy writes nothing
        command(2'b01);
        strobe();
        check_xfer(1'b0, 1'b0);

        // R2: address-only write does not mark a slot fresh
        write_addr(2, 12'h123);
        write_data(3, 24'h00C0DE);
        command(2'b10);
        strobe();
        check_xfer(1'b1, 1'b0);

        // R3: strobe in the same cycle as the command write does not start
        write_data(1, 24'h111111);
        host_wr_en = 1'b1; host_wr_kind = 2'd2; host_wr_slot = '0; host_wr_val = 24'd1;
        frame_strobe = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0; frame_strobe = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(ram_we == 1'b0, "R3 same-cycle strobe ignored", 32'(ram_we), 32'd0);
        end
        chk(cmd_param == 1'b1, "R3 command still pending", 32'(cmd_param), 32'd1);
        strobe();
        check_xfer(1'b0, 1'b0);

        // R12: writing zero does not clear a pending bit
        command(2'b10);
        command(2'b00);
        chk(cmd_target == 1'b1, "R12 zero write keeps target bit", 32'(cmd_target), 32'd1);
        chk(cmd_param == 1'b0, "R12 param bit untouched", 32'(cmd_param), 32'd0);
        write_data(0, 24'h00AB00);
        strobe();
        check_xfer(1'b1, 1'b0);

        // R10: both pending, parameter copy first
        write_addr(0, 12'h000);
        write_data(0, 24'h0F0F0F);
        write_data(1, 24'h0E0E0E);
        command(2'b11);
        chk(cmd_param == 1'b1 && cmd_target == 1'b1, "R10 both bits pending",
            32'({cmd_target, cmd_param}), 32'd3);
        strobe();
        check_xfer(1'b0, 1'b0);
        chk(cmd_target == 1'b1, "R10 target still pending", 32'(cmd_target), 32'd1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(ram_we == 1'b0, "R10 target waits for strobe", 32'(ram_we), 32'd0);
        end
        write_data(4, 24'h044444);
        strobe();
        check_xfer(1'b1, 1'b0);

        // R11: host writes during a copy are ignored
        for (int i = 0; i < NS; i++) write_data(i, DW'(24'h300000 + i));
        command(2'b01);
        strobe();
        check_xfer(1'b0, 1'b1);
        chk(cmd_target == 1'b0, "R11 command write during copy ignored", 32'(cmd_target), 32'd0);
        command(2'b01);
        strobe();
        check_xfer(1'b0, 1'b0);  // R11: slot 4 was not re-marked fresh

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule